// File: doc/BRIEF.md
# Flash Operation Status Tracker

This block holds the 16-bit status word that a flash controller shows to software while an internal operation runs and after it ends. An operation engine pulses a start strobe when it begins work and a done strobe with an outcome code when it stops. The tracker turns these events into a busy flag, an error flag, a timeout flag and a pair of fail flags that cover two-page pipelined cache programming. It also shows the lock state of the protected areas, which it normally reads straight from the lock inputs.

Two outcomes are encoded in special ways. An aborted operation (a reset during program, erase or load) ends with no error. A one-time-programmable area failure forces both OTP lock bits to a fixed value, whatever the lock inputs say, until the next operation starts. The word is built from registered state plus the live lock inputs, so each strobe shows at the port one clock after the edge that samples it.

Top module: `flash_status_tracker`

## Requirements
- R1: After synchronous reset with all lock inputs low, status_o reads 16'h0000.
- R2: A start strobe sets bit 15 (busy) from the next cycle. While bit 15 is 1, bits 10 (error), 3 (previous fail), 2 (current fail) and 0 (timeout) read 0.
- R3: A done strobe while busy clears bit 15. Outcome code 0 (pass) leaves bits 10, 3, 2 and 0 clear. Codes 1 (fail), 2 (locked target) and 7 (reserved) set only bit 10 among them. Code 6 (timeout) sets bits 10 and 0.
- R4: When a done strobe comes with the cache flag high, bit 2 takes the current-page fail input and bit 3 takes the previous-page fail input. Bit 10 is their OR, and the outcome code is ignored.
- R5: Code 3 (reset abort) ends the operation with bits 10, 3, 2 and 0 all 0.
- R6: Code 4 (OTP locked fail) sets bit 10 and forces bits 6 and 5 to 1. Code 5 (OTP fail) sets bit 10 and forces bits 6 and 5 to 0. The forced value holds against the lock inputs until the next start.
- R7: Bit 8 always follows pi_lock_i. Outside an R6 override, bit 6 follows otp_lock_i and bit 5 follows otp1_lock_i.
- R8: A done strobe while not busy changes nothing. When start and done arrive in the same cycle, the start wins.
- R9: Bits 14:11, 9, 7, 4 and 1 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_start_i | input | 1 | Operation start strobe |
| op_done_i | input | 1 | Operation completion strobe |
| op_code_i | input | 3 | Outcome code, sampled with op_done_i |
| cache_i | input | 1 | Completion belongs to a cache program |
| cache_cur_fail_i | input | 1 | Page now being programmed failed |
| cache_prev_fail_i | input | 1 | Page programmed before it failed |
| pi_lock_i | input | 1 | Protected-interval lock state |
| otp_lock_i | input | 1 | OTP area lock state |
| otp1_lock_i | input | 1 | First-block OTP lock state |
| status_o | output | 16 | Status word |

## Verification
A wrong busy register shows up as bit 15 stuck high or low one cycle after a strobe. It also masks or unmasks the error group in that same cycle. A wrong stored outcome appears at the port in the cycle after the done strobe and stays there until the next start, so a single sample per operation catches it. A stuck OTP override is found by moving the OTP lock inputs after an OTP failure and again after the next start. A done strobe that the block fails to ignore while idle changes the error group in the very next cycle.

// File: rtl/ftr_pkg.sv
package ftr_pkg;

    localparam int STAT_W = 16;
    localparam int CODE_W = 3;

    localparam int B_BUSY = 15;
    localparam int B_ERR  = 10;
    localparam int B_PIL  = 8;
    localparam int B_OTPL = 6;
    localparam int B_OTP1 = 5;
    localparam int B_PREV = 3;
    localparam int B_CUR  = 2;
    localparam int B_TMO  = 0;

    typedef enum logic [CODE_W-1:0] {
        OC_PASS       = 3'd0,
        OC_FAIL       = 3'd1,
        OC_LOCKED     = 3'd2,
        OC_RST_ABORT  = 3'd3,
        OC_OTP_LOCKED = 3'd4,
        OC_OTP_FAIL   = 3'd5,
        OC_TIMEOUT    = 3'd6,
        OC_RSVD       = 3'd7
    } op_code_e;

    typedef struct packed {
        logic err;
        logic prev;
        logic cur;
        logic tmo;
        logic otp_force;
        logic otp_val;
    } result_t;

    function automatic result_t decode_result(op_code_e code, logic cache,
                                              logic cur_f, logic prev_f);
        result_t r;
        r = '0;
        if (cache) begin
            r.cur  = cur_f;
            r.prev = prev_f;
            r.err  = cur_f | prev_f;
        end else begin
            unique case (code)
                OC_PASS, OC_RST_ABORT: r.err = 1'b0;
                OC_OTP_LOCKED: begin
                    r.err = 1'b1; r.otp_force = 1'b1; r.otp_val = 1'b1;
                end
                OC_OTP_FAIL: begin
                    r.err = 1'b1; r.otp_force = 1'b1; r.otp_val = 1'b0;
                end
                OC_TIMEOUT: begin
                    r.err = 1'b1; r.tmo = 1'b1;
                end
                default: r.err = 1'b1;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/ftr_decode.sv
module ftr_decode
    import ftr_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    input  logic              cache_i,
    input  logic              cur_fail_i,
    input  logic              prev_fail_i,
    output result_t           upd_o
);
    always_comb begin
        upd_o = decode_result(op_code_e'(code_i), cache_i, cur_fail_i, prev_fail_i);
    end
endmodule

// File: rtl/ftr_state.sv
module ftr_state
    import ftr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start_i,
    input  logic    done_i,
    input  result_t upd_i,
    output logic    busy_o,
    output result_t held_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            busy_o <= 1'b0;
            held_o <= '0;
        end else if (start_i) begin
            busy_o <= 1'b1;
            held_o <= '0;
        end else if (done_i && busy_o) begin
            busy_o <= 1'b0;
            held_o <= upd_i;
        end
    end

    // R2: start makes the block busy
    p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
        start_i |=> busy_o);

    // R3: completion while busy ends the operation
    p_done_idle_r3: assert property (@(posedge clk) disable iff (rst)
        (done_i && busy_o && !start_i) |=> !busy_o);

    // R5: a reset abort leaves no error behind
    p_abort_noerr_r5: assert property (@(posedge clk) disable iff (rst)
        (done_i && busy_o && !start_i && !upd_i.err && !upd_i.tmo) |=> !held_o.err);

    // R8: a completion while idle is ignored
    p_idle_done_r8: assert property (@(posedge clk) disable iff (rst)
        (done_i && !busy_o && !start_i) |=> ($stable(held_o) && !busy_o));
endmodule

// File: rtl/ftr_pack.sv
module ftr_pack
    import ftr_pkg::*;
(
    input  logic              busy_i,
    input  result_t           held_i,
    input  logic              pi_lock_i,
    input  logic              otp_lock_i,
    input  logic              otp1_lock_i,
    output logic [STAT_W-1:0] word_o
);
    logic show;
    assign show = !busy_i;

    always_comb begin
        word_o          = '0;
        word_o[B_BUSY]  = busy_i;
        word_o[B_ERR]   = show & held_i.err;
        word_o[B_PREV]  = show & held_i.prev;
        word_o[B_CUR]   = show & held_i.cur;
        word_o[B_TMO]   = show & held_i.tmo;
        word_o[B_PIL]   = pi_lock_i;
        word_o[B_OTPL]  = held_i.otp_force ? held_i.otp_val : otp_lock_i;
        word_o[B_OTP1]  = held_i.otp_force ? held_i.otp_val : otp1_lock_i;
    end
endmodule

// File: rtl/flash_status_tracker.sv
module flash_status_tracker
    import ftr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_start_i,
    input  logic              op_done_i,
    input  logic [CODE_W-1:0] op_code_i,
    input  logic              cache_i,
    input  logic              cache_cur_fail_i,
    input  logic              cache_prev_fail_i,
    input  logic              pi_lock_i,
    input  logic              otp_lock_i,
    input  logic              otp1_lock_i,
    output logic [STAT_W-1:0] status_o
);
    localparam logic [STAT_W-1:0] USED_MASK =
        (STAT_W'(1) << B_BUSY) | (STAT_W'(1) << B_ERR)  | (STAT_W'(1) << B_PIL) |
        (STAT_W'(1) << B_OTPL) | (STAT_W'(1) << B_OTP1) | (STAT_W'(1) << B_PREV) |
        (STAT_W'(1) << B_CUR)  | (STAT_W'(1) << B_TMO);

    result_t upd;
    result_t held;
    logic    busy;

    ftr_decode u_decode (
        .code_i      (op_code_i),
        .cache_i     (cache_i),
        .cur_fail_i  (cache_cur_fail_i),
        .prev_fail_i (cache_prev_fail_i),
        .upd_o       (upd)
    );

    ftr_state u_state (
        .clk     (clk),
        .rst     (rst),
        .start_i (op_start_i),
        .done_i  (op_done_i),
        .upd_i   (upd),
        .busy_o  (busy),
        .held_o  (held)
    );

    ftr_pack u_pack (
        .busy_i      (busy),
        .held_i      (held),
        .pi_lock_i   (pi_lock_i),
        .otp_lock_i  (otp_lock_i),
        .otp1_lock_i (otp1_lock_i),
        .word_o      (status_o)
    );

    // R9: unused bit positions stay zero
    p_reserved_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (status_o & ~USED_MASK) == '0);

    // R2: while busy the outcome group is hidden
    p_busy_mask_r2: assert property (@(posedge clk) disable iff (rst)
        status_o[B_BUSY] |-> (status_o[B_ERR] == 1'b0 && status_o[B_PREV] == 1'b0 &&
                              status_o[B_CUR] == 1'b0 && status_o[B_TMO] == 1'b0));

    // R7: protected-interval lock is always live
    p_pil_live_r7: assert property (@(posedge clk) disable iff (rst)
        status_o[B_PIL] == pi_lock_i);
endmodule

// File: tb/flash_status_tracker_tb.sv
module flash_status_tracker_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_start_i = 1'b0;
    logic        op_done_i = 1'b0;
    logic [2:0]  op_code_i = 3'd0;
    logic        cache_i = 1'b0;
    logic        cache_cur_fail_i = 1'b0;
    logic        cache_prev_fail_i = 1'b0;
    logic        pi_lock_i = 1'b0;
    logic        otp_lock_i = 1'b0;
    logic        otp1_lock_i = 1'b0;
    logic [15:0] status_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [15:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];

    always #5 clk = ~clk;

    flash_status_tracker u_dut (
        .clk(clk), .rst(rst), .op_start_i(op_start_i), .op_done_i(op_done_i),
        .op_code_i(op_code_i), .cache_i(cache_i), .cache_cur_fail_i(cache_cur_fail_i),
        .cache_prev_fail_i(cache_prev_fail_i), .pi_lock_i(pi_lock_i),
        .otp_lock_i(otp_lock_i), .otp1_lock_i(otp1_lock_i), .status_o(status_o)
    );

    // monitor: pops expected words and compares at the falling edge
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            checks++;
            if (status_o !== it.exp) begin
                errors++;
                $display("FAIL %s: status=%h expected=%h", it.tag, status_o, it.exp);
            end
        end
    end

    task automatic expect_word(input logic [15:0] exp, input string tag);
        item_t it;
        it.exp = exp;
        it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
        #1;
    endtask

    task automatic drive(input logic st, input logic dn, input logic [2:0] code,
                         input logic ca, input logic cf, input logic pf,
                         input logic [15:0] exp, input string tag);
        @(negedge clk);
        op_start_i = st; op_done_i = dn; op_code_i = code;
        cache_i = ca; cache_cur_fail_i = cf; cache_prev_fail_i = pf;
        @(posedge clk);
        #1;
        op_start_i = 1'b0; op_done_i = 1'b0; cache_i = 1'b0;
        cache_cur_fail_i = 1'b0; cache_prev_fail_i = 1'b0; op_code_i = 3'd0;
        expect_word(exp, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        expect_word(16'h0000, "R1 reset word");

        pi_lock_i = 1'b1;
        expect_word(16'h0100, "R7 pi lock live");
        pi_lock_i = 1'b0;

        drive(1, 0, 3'd0, 0, 0, 0, 16'h8000, "R2 start sets busy");
        drive(0, 1, 3'd1, 0, 0, 0, 16'h0400, "R3 fail code");
        drive(1, 0, 3'd0, 0, 0, 0, 16'h8000, "R2 busy masks error");
        drive(0, 1, 3'd2, 0, 0, 0, 16'h0400, "R3 locked target");
        drive(1, 0, 3'd0, 0, 0, 0, 16'h8000, "R2 restart");
        drive(0, 1, 3'd6, 0, 0, 0, 16'h0401, "R3 timeout");
        drive(1, 0, 3'd0, 0, 0, 0, 16'h8000, "R2 restart");
        drive(0, 1, 3'd0, 0, 0, 0, 16'h0000, "R3 pass");
        drive(1, 0, 3'd0, 0, 0, 0, 16'h8000, "R2 restart");
        drive(0, 1, 3'd7, 0, 0, 0, 16'h0400, "R3 reserved code");
        drive(1, 0, 3'd0, 0, 0, 0, 16'h8000, "R2 restart");
        drive(0, 1, 3'd3, 0, 0, 0, 16'h0000, "R5 reset abort no error");

        drive(1, 0, 3'd0, 0, 0, 0, 16'h8000, "R2 cache start");
        drive(0, 1, 3'd0, 1, 1, 0, 16'h0404, "R4 current fail, code ignored");
        drive(1, 0, 3'd0, 0, 0, 0, 16'h8000, "R2 restart");
        drive(0, 1, 3'd1, 1, 0, 1, 16'h0408, "R4 previous fail");
        drive(1, 0, 3'd0, 0, 0, 0, 16'h8000, "R2 restart");
        drive(0, 1, 3'd0, 1, 1, 1, 16'h040C, "R4 both fail");
        drive(1, 0, 3'd0, 0, 0, 0, 16'h8000, "R2 restart");
        drive(0, 1, 3'd1, 1, 0, 0, 16'h0000, "R4 both pass, fail code ignored");

        drive(1, 0, 3'd0, 0, 0, 0, 16'h8000, "R2 restart");
        drive(0, 1, 3'd4, 0, 0, 0, 16'h0460, "R6 otp locked fail");
        otp_lock_i = 1'b1; otp1_lock_i = 1'b1;
        expect_word(16'h0460, "R6 override holds inputs high");
        drive(1, 0, 3'd0, 0, 0, 0, 16'h8060, "R7 start restores live otp bits");
        drive(0, 1, 3'd5, 0, 0, 0, 16'h0400, "R6 otp fail forces zero");
        otp_lock_i = 1'b0; otp1_lock_i = 1'b1;
        expect_word(16'h0400, "R6 zero override holds");
        drive(1, 0, 3'd0, 0, 0, 0, 16'h8020, "R7 first-block otp live");
        otp1_lock_i = 1'b0;
        drive(0, 1, 3'd1, 0, 0, 0, 16'h0400, "R3 fail code");

        drive(0, 1, 3'd0, 0, 0, 0, 16'h0400, "R8 idle pass done ignored");
        drive(0, 1, 3'd6, 0, 0, 0, 16'h0400, "R8 idle timeout done ignored");
        drive(1, 1, 3'd0, 0, 0, 0, 16'h8000, "R8 start wins over done");
        drive(0, 1, 3'd6, 0, 0, 0, 16'h0401, "R9 word with timeout");

        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run hung, actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule